// File: doc/BRIEF.md
# I2C SCL/SDA timing generator

This block produces the serial clock of an I2C controller and tells the transfer engine when to move SDA. It takes a divisor word that carries a low count and a high count, and an 8-bit tuning word. Each SCL half-period is split into eight slices. A low slice lasts `divl+1` input clocks and a high slice lasts `divh+1` input clocks. The tuning word selects the slice in which SDA changes during the low phase. It also sets how long SCL stays high before a START marker and before a STOP marker. Each of these stretches is a whole number of high-slice groups.

The engine pulses `start_req_i` to begin a run. The generator then walks through four stages: START setup, START hold, alternating low and high phases, and, once `stop_req_i` has been seen, a STOP setup after which it goes idle. The outputs are the SCL level, single-cycle strobes at each SCL edge, an SDA update strobe, and markers where SDA should fall for START and rise for STOP. Byte sequencing and register access are handled outside this block.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: In reset and whenever no run is active, `scl_o` is 1, `busy_o` is 0, and every strobe and marker is 0.
- R2: The divisor holds the low count in bits CNT_W-1:0 and the high count in bits 2*CNT_W-1:CNT_W. With l = low count + 1, each low phase keeps `scl_o` at 0 for exactly 8*l cycles, and `scl_fall_o` pulses in its first cycle.
- R3: With h = high count + 1, each high phase between two low phases keeps `scl_o` at 1 for 8*h cycles. `scl_rise_o` pulses in the first cycle of every high stretch that follows a low phase.
- R4: With s = tuning bits 1:0 plus one, `sda_upd_o` pulses exactly once per low phase, in the cycle with 0-based index l*s counted from the phase's first low cycle.
- R5: With u = tuning bits 5:4 plus one, after an accepted `start_req_i` `scl_o` stays 1 and `sta_mark_o` pulses in cycle 8*h*u. Cycle 1 is the cycle after the clock edge that accepted the request.
- R6: After the `sta_mark_o` cycle, `scl_o` stays 1 for 8*h*(u+1) more cycles, and then the first low phase begins.
- R7: A `stop_req_i` that arrives during a run, before the last cycle of a low phase, ends that low phase with a STOP. With p = tuning bits 7:6 plus one, `scl_o` is then 1 and `sto_mark_o` pulses in the 8*h*p-th high cycle. In the next cycle `busy_o` is 0.
- R8: `start_req_i` is ignored when either divisor count is zero and while a run is active. `stop_req_i` is ignored while idle and does not carry into a later run.
- R9: The divisor and tuning are sampled only when a run starts and at each entry to a low phase. A change in the middle of a low phase alters neither that low phase nor the high phase after it.
- R10: If either divisor count is zero when a low phase would begin, the run ends: `busy_o` falls and `scl_o` stays 1.
- R11: At most one of `scl_fall_o`, `scl_rise_o`, `sda_upd_o`, `sta_mark_o` and `sto_mark_o` is high in any cycle. Tuning bits 3:2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor_i | input | 2*CNT_W | High count (upper half) and low count (lower half) |
| tuning_i | input | 8 | SDA slice [1:0], START stretch [5:4], STOP stretch [7:6] |
| start_req_i | input | 1 | Pulse that begins a run from idle |
| stop_req_i | input | 1 | Pulse that asks for a STOP at the end of a low phase |
| scl_o | output | 1 | Serial clock level (1 = released) |
| busy_o | output | 1 | A run is active |
| scl_fall_o | output | 1 | First cycle of a low phase |
| scl_rise_o | output | 1 | First cycle of a high stretch after a low phase |
| sda_upd_o | output | 1 | Cycle in which the engine changes SDA |
| sta_mark_o | output | 1 | SDA should fall for START after this cycle |
| sto_mark_o | output | 1 | SDA should rise for STOP after this cycle |

## Verification
The bench builds the block with CNT_W = 4 and SLICES = 8. The narrow count field lets the bench reach the all-ones low and high counts within a few hundred cycles, so the largest slice length is exercised next to the smallest. It pairs several divisor and tuning combinations with START, hold and STOP stretch products from 16 up to 256 cycles, and with every SDA slice choice. Directed runs change or zero the divisor in the middle of a phase to observe when the new value takes effect.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    // Largest stretch multiple a tuning setting can ask for (START hold: 3 + 2).
    localparam int MAX_MULT = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STA_SU,
        PH_STA_HD,
        PH_LOW,
        PH_HIGH,
        PH_STO_SU
    } phase_e;

    // Number of slice groups (each SLICES slices long) a phase lasts.
    function automatic logic [2:0] phase_mult(phase_e ph, logic [1:0] sta, logic [1:0] sto);
        case (ph)
            PH_STA_SU: return {1'b0, sta} + 3'd1;
            PH_STA_HD: return {1'b0, sta} + 3'd2;
            PH_STO_SU: return {1'b0, sto} + 3'd1;
            default:   return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/i2c_tg_cfg.sv
module i2c_tg_cfg #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [2*CNT_W-1:0] div_i,
    input  logic [7:0]         tune_i,
    output logic [CNT_W-1:0]   low_m1_o,
    output logic [CNT_W-1:0]   high_m1_o,
    output logic [1:0]         sda_o,
    output logic [1:0]         sta_o,
    output logic [1:0]         sto_o
);
    // Bits 3:2 of the tuning word carry no function.
    logic unused_spare;
    assign unused_spare = ^tune_i[3:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            low_m1_o  <= '0;
            high_m1_o <= '0;
            sda_o     <= '0;
            sta_o     <= '0;
            sto_o     <= '0;
        end else if (load_i) begin
            low_m1_o  <= div_i[CNT_W-1:0];
            high_m1_o <= div_i[2*CNT_W-1:CNT_W];
            sda_o     <= tune_i[1:0];
            sta_o     <= tune_i[5:4];
            sto_o     <= tune_i[7:6];
        end
    end
endmodule

// File: rtl/i2c_tg_slicer.sv
module i2c_tg_slicer #(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic [CNT_W-1:0]  len_m1_i,
    output logic [CNT_W-1:0]  slice_o,
    output logic [STEP_W-1:0] step_o,
    output logic              slice_end_o
);
    assign slice_end_o = (slice_o == len_m1_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            slice_o <= '0;
            step_o  <= '0;
        end else if (slice_end_o) begin
            slice_o <= '0;
            step_o  <= step_o + STEP_W'(1);
        end else begin
            slice_o <= slice_o + CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2c_tg_phase_fsm.sv
module i2c_tg_phase_fsm
    import i2c_tg_pkg::*;
#(
    parameter int SLICES = 8,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req_i,
    input  logic              stop_req_i,
    input  logic              div_ok_i,
    input  logic              slice_end_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [1:0]        sta_i,
    input  logic [1:0]        sto_i,
    output phase_e            phase_o,
    output logic              done_o,
    output logic              load_o,
    output logic              restart_o
);
    phase_e            phase_q;
    phase_e            phase_d;
    logic              stop_pend_q;
    logic              done;
    logic [STEP_W-1:0] last_step;

    always_comb last_step = STEP_W'(SLICES * int'(phase_mult(phase_q, sta_i, sto_i)) - 1);

    assign done = (phase_q != PH_IDLE) && slice_end_i && (step_i == last_step);

    always_comb begin
        phase_d = phase_q;
        load_o  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_req_i && div_ok_i) begin
                    phase_d = PH_STA_SU;
                    load_o  = 1'b1;
                end
            end
            PH_STA_SU: begin
                if (done) phase_d = PH_STA_HD;
            end
            PH_STA_HD, PH_HIGH: begin
                if (done) begin
                    if (div_ok_i) begin
                        phase_d = PH_LOW;
                        load_o  = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_LOW: begin
                if (done) phase_d = stop_pend_q ? PH_STO_SU : PH_HIGH;
            end
            PH_STO_SU: begin
                if (done) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            stop_pend_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_d == PH_IDLE)
                stop_pend_q <= 1'b0;
            else if (stop_req_i && phase_q != PH_IDLE)
                stop_pend_q <= 1'b1;
        end
    end

    assign phase_o   = phase_q;
    assign done_o    = done;
    assign restart_o = (phase_q == PH_IDLE) || done;
endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
    import i2c_tg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SLICES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*CNT_W-1:0] divisor_i,
    input  logic [7:0]         tuning_i,
    input  logic               start_req_i,
    input  logic               stop_req_i,
    output logic               scl_o,
    output logic               busy_o,
    output logic               scl_fall_o,
    output logic               scl_rise_o,
    output logic               sda_upd_o,
    output logic               sta_mark_o,
    output logic               sto_mark_o
);
    localparam int STEP_W = $clog2(SLICES * MAX_MULT);

    logic [CNT_W-1:0]  low_m1, high_m1, len_m1, slice_q;
    logic [1:0]        sda_q, sta_q, sto_q;
    logic [STEP_W-1:0] step_q;
    logic              slice_end, load, restart, done, div_ok, first;
    phase_e            phase;

    assign div_ok = (|divisor_i[CNT_W-1:0]) && (|divisor_i[2*CNT_W-1:CNT_W]);

    i2c_tg_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .div_i     (divisor_i),
        .tune_i    (tuning_i),
        .low_m1_o  (low_m1),
        .high_m1_o (high_m1),
        .sda_o     (sda_q),
        .sta_o     (sta_q),
        .sto_o     (sto_q)
    );

    assign len_m1 = (phase == PH_LOW) ? low_m1 : high_m1;

    i2c_tg_slicer #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_slicer (
        .clk         (clk),
        .rst         (rst),
        .restart_i   (restart),
        .len_m1_i    (len_m1),
        .slice_o     (slice_q),
        .step_o      (step_q),
        .slice_end_o (slice_end)
    );

    i2c_tg_phase_fsm #(.SLICES(SLICES), .STEP_W(STEP_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req_i (start_req_i),
        .stop_req_i  (stop_req_i),
        .div_ok_i    (div_ok),
        .slice_end_i (slice_end),
        .step_i      (step_q),
        .sta_i       (sta_q),
        .sto_i       (sto_q),
        .phase_o     (phase),
        .done_o      (done),
        .load_o      (load),
        .restart_o   (restart)
    );

    assign first      = (slice_q == '0) && (step_q == '0);
    assign scl_o      = (phase != PH_LOW);
    assign busy_o     = (phase != PH_IDLE);
    assign scl_fall_o = (phase == PH_LOW) && first;
    assign scl_rise_o = ((phase == PH_HIGH) || (phase == PH_STO_SU)) && first;
    assign sda_upd_o  = (phase == PH_LOW) && (slice_q == '0) &&
                        (step_q == STEP_W'(int'(sda_q) + 1));
    assign sta_mark_o = (phase == PH_STA_SU) && done;
    assign sto_mark_o = (phase == PH_STO_SU) && done;
endmodule

// File: rtl/i2c_tg_checker.sv
module i2c_tg_checker (
    input logic clk,
    input logic rst,
    input logic start_req_i,
    input logic scl_o,
    input logic busy_o,
    input logic scl_fall_o,
    input logic scl_rise_o,
    input logic sda_upd_o,
    input logic sta_mark_o,
    input logic sto_mark_o
);
    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> scl_o);

    p_fall_edge_r2: assert property (@(posedge clk) disable iff (rst)
        scl_fall_o |-> (!scl_o && $past(scl_o)));

    p_rise_edge_r3: assert property (@(posedge clk) disable iff (rst)
        scl_rise_o |-> (scl_o && !$past(scl_o)));

    p_upd_in_low_r4: assert property (@(posedge clk) disable iff (rst)
        sda_upd_o |-> (!scl_o && !$past(scl_o)));

    p_sta_high_r5: assert property (@(posedge clk) disable iff (rst)
        sta_mark_o |-> (scl_o && busy_o));

    p_sta_hold_r6: assert property (@(posedge clk) disable iff (rst)
        sta_mark_o |=> (scl_o && busy_o));

    p_sto_ends_r7: assert property (@(posedge clk) disable iff (rst)
        sto_mark_o |=> (!busy_o && scl_o));

    p_start_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_req_i));

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scl_fall_o, scl_rise_o, sda_upd_o, sta_mark_o, sto_mark_o}));
endmodule

bind i2c_scl_timing_gen i2c_tg_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .start_req_i (start_req_i),
    .scl_o       (scl_o),
    .busy_o      (busy_o),
    .scl_fall_o  (scl_fall_o),
    .scl_rise_o  (scl_rise_o),
    .sda_upd_o   (sda_upd_o),
    .sta_mark_o  (sta_mark_o),
    .sto_mark_o  (sto_mark_o)
);

// File: tb/tb_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_i2c_scl_timing_gen;
    localparam int CNT_W = 4;
    localparam int LIM   = 5000;
    localparam int NVEC  = 5;
    // {tuning[7:0], high count[3:0], low count[3:0]}
    localparam logic [15:0] VECS [NVEC] = '{16'h0011, 16'h9112, 16'hF331, 16'h42FF, 16'h2E24};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2*CNT_W-1:0] divisor = '0;
    logic [7:0] tuning = '0;
    logic start_req = 1'b0;
    logic stop_req = 1'b0;
    logic scl_o, busy_o, scl_fall_o, scl_rise_o, sda_upd_o, sta_mark_o, sto_mark_o;
    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    i2c_scl_timing_gen #(.CNT_W(CNT_W), .SLICES(8)) dut (
        .clk(clk), .rst(rst), .divisor_i(divisor), .tuning_i(tuning),
        .start_req_i(start_req), .stop_req_i(stop_req),
        .scl_o(scl_o), .busy_o(busy_o), .scl_fall_o(scl_fall_o),
        .scl_rise_o(scl_rise_o), .sda_upd_o(sda_upd_o),
        .sta_mark_o(sta_mark_o), .sto_mark_o(sto_mark_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic wait_low();
        int n = 0;
        while (scl_o && n < LIM) begin @(negedge clk); n++; end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!scl_o && n < LIM) begin n++; @(negedge clk); end
    endtask

    task automatic count_high_busy(output int n);
        n = 0;
        while (scl_o && busy_o && n < LIM) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        int n = 0;
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        while (busy_o && n < LIM) begin n++; @(negedge clk); end
        chk(!busy_o, "R7 run ends after stop", int'(busy_o), 0);
    endtask

    task automatic run_vec(input logic [15:0] v);
        int l, h, s, u, p, n, upd, nupd;
        l = int'(v[3:0]) + 1;  h = int'(v[7:4]) + 1;
        s = int'(v[9:8]) + 1;  u = int'(v[13:12]) + 1;  p = int'(v[15:14]) + 1;
        divisor = v[7:0];
        tuning  = v[15:8];
        pulse_start();
        n = 1;
        while (!sta_mark_o && n < LIM) begin @(negedge clk); n++; end
        chk(n == 8*h*u, "R5 start setup", n, 8*h*u);
        @(negedge clk);
        n = 0;
        while (scl_o && n < LIM) begin n++; @(negedge clk); end
        chk(n == 8*h*(u+1), "R6 start hold", n, 8*h*(u+1));
        chk(scl_fall_o == 1'b1, "R2 fall strobe", int'(scl_fall_o), 1);
        n = 0; upd = -1; nupd = 0;
        while (!scl_o && n < LIM) begin
            if (sda_upd_o) begin upd = n; nupd++; end
            n++; @(negedge clk);
        end
        chk(n == 8*l, "R2 low length", n, 8*l);
        chk(upd == l*s, "R4 sda slice", upd, l*s);
        chk(nupd == 1, "R4 one update", nupd, 1);
        chk(scl_rise_o == 1'b1, "R3 rise strobe", int'(scl_rise_o), 1);
        count_high_busy(n);
        chk(n == 8*h, "R3 high length", n, 8*h);
        stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        n = 1;
        while (!scl_o && n < LIM) begin n++; @(negedge clk); end
        chk(n == 8*l, "R2 low before stop", n, 8*l);
        n = 1;
        while (!sto_mark_o && n < LIM) begin @(negedge clk); n++; end
        chk(n == 8*h*p, "R7 stop setup", n, 8*h*p);
        @(negedge clk);
        chk(!busy_o && scl_o, "R7 idle after stop", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        bit seen;
        repeat (4) @(negedge clk);
        chk(scl_o && !busy_o, "R1 reset state", int'(scl_o), 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(scl_o && !busy_o && !scl_fall_o && !scl_rise_o && !sda_upd_o
            && !sta_mark_o && !sto_mark_o, "R1 idle after reset", int'(busy_o), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R8: zero low count or zero high count blocks a start
        for (int k = 0; k < 2; k++) begin
            divisor = (k == 0) ? 8'h50 : 8'h05;
            pulse_start();
            seen = 1'b0;
            for (int c = 0; c < 20; c++) begin
                if (busy_o || !scl_o) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R8 zero count ignored", int'(seen), 0);
        end

        // R8: start while busy does not restart the setup stretch
        divisor = 8'h11; tuning = 8'h00;
        pulse_start();
        repeat (4) @(negedge clk);
        start_req = 1'b1; @(negedge clk); start_req = 1'b0;
        n = 6;
        while (!sta_mark_o && n < LIM) begin @(negedge clk); n++; end
        chk(n == 16, "R8 start while busy", n, 16);
        finish_run();

        // R8: stop while idle does not carry into the next run
        @(negedge clk); stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        repeat (3) @(negedge clk);
        pulse_start();
        wait_low();
        count_low(n);
        count_high_busy(n);
        chk(n == 16 && busy_o, "R8 stop in idle ignored", n, 16);
        finish_run();

        // R9: mid-phase divisor change waits for the next low boundary
        divisor = 8'h11;
        pulse_start();
        wait_low();
        n = 0;
        while (!scl_o && n < LIM) begin
            if (n == 3) divisor = 8'h33;
            n++; @(negedge clk);
        end
        chk(n == 16, "R9 current low kept", n, 16);
        count_high_busy(n);
        chk(n == 16, "R9 following high kept", n, 16);
        count_low(n);
        chk(n == 32, "R9 new low applied", n, 32);
        count_high_busy(n);
        chk(n == 32, "R9 new high applied", n, 32);
        finish_run();

        // R10: zero high count at a low boundary ends the run
        divisor = 8'h11;
        pulse_start();
        wait_low();
        n = 0;
        while (!scl_o && n < LIM) begin
            if (n == 3) divisor = 8'h01;
            n++; @(negedge clk);
        end
        count_high_busy(n);
        chk(n == 16, "R10 last high length", n, 16);
        chk(!busy_o && scl_o, "R10 run ended", int'(busy_o), 0);
        seen = 1'b0;
        for (int c = 0; c < 10; c++) begin
            if (busy_o || !scl_o) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R10 stays idle", int'(seen), 0);

        // R11: spare tuning bits 3:2 set, timing unchanged (vector 5 already), recheck sda slot
        divisor = 8'h11; tuning = 8'h0C;
        pulse_start();
        wait_low();
        n = 0; seen = 1'b0;
        while (!scl_o && n < LIM) begin
            if (sda_upd_o && n == 2) seen = 1'b1;
            n++; @(negedge clk);
        end
        chk(seen, "R11 spare bits no effect", int'(seen), 1);
        finish_run();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule